// File: doc/BRIEF.md
# UART Interrupt Source Prioritiser

This block gathers every interrupt condition of one serial channel, masks them with per-source enables, selects the single most urgent pending source and publishes it as an 8-bit identification byte for the host to read. An interrupt request line goes high whenever any enabled source is pending. The host reads the byte, uses the low bits to dispatch, and the read strobe clears the event-type sources it reported.

Receiver error, receive timeout, receive data available and modem change are level conditions supplied by neighbouring logic; they are shown for as long as they hold. Transmit-ready, Xoff match, special-character match and CTS/RTS deassertion arrive as one-cycle pulses and are latched here. The three enhanced sources work only while the enhanced-features enable is high. The top two bits of the byte mirror the FIFO-enable flag.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with no source active and FIFOs off, the status byte reads 0x01; bit 0 is 0 exactly when an enabled source is pending.
- R2: Ranking from highest to lowest is: line error, receive timeout, data ready, transmit ready, modem change, Xoff/special match, CTS/RTS deassertion. Bits 5:0 read 000110, 001100, 000100, 000010, 000000, 010000, 100000 respectively, and 000001 when nothing is pending.
- R3: A source whose bit in `src_en_i` (bit index = rank, 0 highest) is 0 never appears in the status byte and does not raise the request.
- R4: Bits 7:6 both equal `fifo_en_i`.
- R5: A transmit-ready pulse latches; a status read clears it only when that read reported transmit ready (bits 5:0 = 000010). A read reporting another source leaves it pending.
- R6: With enhanced mode on, an Xoff pulse latches (bit 4); it clears on a status read that reported it, and a received-character strobe does not clear it.
- R7: With enhanced mode on, a special-character pulse latches (bit 4); it clears on a status read that reported it or on the next received-character strobe.
- R8: With enhanced mode on, a CTS/RTS deassertion pulse latches (bit 5) and clears on a status read that reported it.
- R9: While enhanced mode is off, bits 5:4 read 0, enhanced pulses are ignored, and enhanced flags pending when it turns off are discarded.
- R10: Level sources follow their inputs; a status read does not clear them.
- R11: `irq_o` is always the inverse of status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_err_i | input | 1 | Receiver line error condition (level) |
| rx_tmo_i | input | 1 | Receive timeout condition (level) |
| rx_rdy_i | input | 1 | Receive data available (level) |
| tx_rdy_pls_i | input | 1 | Transmitter became ready (pulse) |
| modem_chg_i | input | 1 | Modem status change pending (level) |
| xoff_hit_i | input | 1 | Xoff character matched (pulse) |
| spec_hit_i | input | 1 | Special character matched (pulse) |
| flow_drop_i | input | 1 | CTS or RTS deasserted (pulse) |
| src_en_i | input | 7 | Per-source enables, bit index = rank |
| enh_en_i | input | 1 | Enhanced-features enable |
| fifo_en_i | input | 1 | FIFOs enabled flag |
| stat_rd_i | input | 1 | Status byte read strobe |
| rx_char_i | input | 1 | Character received strobe |
| stat_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A stuck or lost event flag shows at the ports one cycle after the pulse or read that should have moved it, either as a code that fails to appear or one that survives its clearing read. A wrong ranking or mask shows immediately as the wrong code whenever two sources are pending together, so the directed scenarios stack sources and peel them off one at a time. A clear that fires for the wrong reported source shows only once the higher source goes away, so those scenarios drop the higher level source after the read and look again.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 7;
  localparam int NEVT = 4;

  typedef enum logic [2:0] {
    S_LINE = 3'd0,
    S_TMO  = 3'd1,
    S_RDY  = 3'd2,
    S_THR  = 3'd3,
    S_MDM  = 3'd4,
    S_XSP  = 3'd5,
    S_FLOW = 3'd6,
    S_NONE = 3'd7
  } src_e;

  // event latch slots
  localparam int E_THR  = 0;
  localparam int E_XOFF = 1;
  localparam int E_SPEC = 2;
  localparam int E_FLOW = 3;

  function automatic logic [5:0] src_code(src_e s);
    case (s)
      S_LINE:  return 6'b000110;
      S_TMO:   return 6'b001100;
      S_RDY:   return 6'b000100;
      S_THR:   return 6'b000010;
      S_MDM:   return 6'b000000;
      S_XSP:   return 6'b010000;
      S_FLOW:  return 6'b100000;
      default: return 6'b000001;
    endcase
  endfunction
endpackage

// File: rtl/uirq_rst_sync.sv
module uirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  // set takes precedence over clear in the same cycle
  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  a_r5_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req_i,
  output src_e         sel_o
);
  always_comb begin
    sel_o = S_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) sel_o = src_e'(i);
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_err_i,
  input  logic            rx_tmo_i,
  input  logic            rx_rdy_i,
  input  logic            tx_rdy_pls_i,
  input  logic            modem_chg_i,
  input  logic            xoff_hit_i,
  input  logic            spec_hit_i,
  input  logic            flow_drop_i,
  input  logic [NSRC-1:0] src_en_i,
  input  logic            enh_en_i,
  input  logic            fifo_en_i,
  input  logic            stat_rd_i,
  input  logic            rx_char_i,
  output logic [7:0]      stat_o,
  output logic            irq_o
);
  logic            rst_sync_n;
  logic [NEVT-1:0] evt_set, evt_clr, evt_q;
  logic [NSRC-1:0] raw_req, req;
  src_e            sel;
  logic            rd_thr, rd_xsp, rd_flow;

  uirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // reads clear only the source they reported
  always_comb begin
    rd_thr  = stat_rd_i && (sel == S_THR);
    rd_xsp  = stat_rd_i && (sel == S_XSP);
    rd_flow = stat_rd_i && (sel == S_FLOW);

    evt_set         = '0;
    evt_set[E_THR]  = tx_rdy_pls_i;
    evt_set[E_XOFF] = xoff_hit_i  & enh_en_i;
    evt_set[E_SPEC] = spec_hit_i  & enh_en_i;
    evt_set[E_FLOW] = flow_drop_i & enh_en_i;

    evt_clr         = '0;
    evt_clr[E_THR]  = rd_thr;
    evt_clr[E_XOFF] = rd_xsp  | ~enh_en_i;
    evt_clr[E_SPEC] = rd_xsp  | rx_char_i | ~enh_en_i;
    evt_clr[E_FLOW] = rd_flow | ~enh_en_i;
  end

  for (genvar g = 0; g < NEVT; g++) begin : g_evt
    uirq_sticky u_flag (
      .clk(clk), .rst_n(rst_sync_n),
      .set_i(evt_set[g]), .clr_i(evt_clr[g]), .flag_o(evt_q[g])
    );
  end

  always_comb begin
    raw_req         = '0;
    raw_req[S_LINE] = line_err_i;
    raw_req[S_TMO]  = rx_tmo_i;
    raw_req[S_RDY]  = rx_rdy_i;
    raw_req[S_THR]  = evt_q[E_THR];
    raw_req[S_MDM]  = modem_chg_i;
    raw_req[S_XSP]  = (evt_q[E_XOFF] | evt_q[E_SPEC]) & enh_en_i;
    raw_req[S_FLOW] = evt_q[E_FLOW] & enh_en_i;
    req             = raw_req & src_en_i;
  end

  uirq_prio #(.N(NSRC)) u_prio (.req_i(req), .sel_o(sel));

  assign stat_o = {{2{fifo_en_i}}, src_code(sel)};
  assign irq_o  = |req;

  a_r11_irq_vs_bit0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o != stat_o[0]);
  a_r9_enh_off_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enh_en_i |-> stat_o[5:4] == 2'b00);
  a_r3_line_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !src_en_i[S_LINE] |-> stat_o[3:0] != 4'b0110);
  a_r5_thr_read_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_rd_i && stat_o[5:0] == 6'b000010 && !tx_rdy_pls_i) |=> !evt_q[E_THR]);
  a_r7_spec_auto_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_char_i && !spec_hit_i) |=> !evt_q[E_SPEC]);
  a_r4_fifo_bits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stat_o[7] == fifo_en_i && stat_o[6] == fifo_en_i);
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_err, rx_tmo, rx_rdy, tx_pls, mdm, xoff, spec, flow;
  logic [6:0] src_en;
  logic       enh, fifo_en, rd, rxc;
  logic [7:0] stat;
  logic       irq;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  uart_irq_ident u_dut (
    .clk(clk), .rst_n(rst_n), .line_err_i(line_err), .rx_tmo_i(rx_tmo),
    .rx_rdy_i(rx_rdy), .tx_rdy_pls_i(tx_pls), .modem_chg_i(mdm),
    .xoff_hit_i(xoff), .spec_hit_i(spec), .flow_drop_i(flow),
    .src_en_i(src_en), .enh_en_i(enh), .fifo_en_i(fifo_en),
    .stat_rd_i(rd), .rx_char_i(rxc), .stat_o(stat), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (stat !== exp || irq !== ~exp[0]) begin
      n_bad++;
      $display("FAIL %s: stat=%02h irq=%b expected stat=%02h irq=%b",
               req, stat, irq, exp, ~exp[0]);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_tx();   tx_pls = 1; step(); tx_pls = 0; endtask
  task automatic pulse_xoff(); xoff = 1;   step(); xoff = 0;   endtask
  task automatic pulse_spec(); spec = 1;   step(); spec = 0;   endtask
  task automatic pulse_flow(); flow = 1;   step(); flow = 0;   endtask
  task automatic pulse_rxc();  rxc = 1;    step(); rxc = 0;    endtask
  task automatic do_read();    rd = 1;     step(); rd = 0;     endtask

  task automatic t_reset();
    chk("R1 reset", 8'h01);
  endtask

  task automatic t_levels();
    line_err = 1; rx_tmo = 1; rx_rdy = 1; mdm = 1; step();
    chk("R2 line top", 8'h06);
    do_read();
    chk("R10 read keeps level", 8'h06);
    line_err = 0; step(); chk("R2 timeout", 8'h0C);
    rx_tmo = 0;   step(); chk("R2 data ready", 8'h04);
    rx_rdy = 0;   step(); chk("R11 modem irq", 8'h00);
    mdm = 0;      step(); chk("R2 none", 8'h01);
  endtask

  task automatic t_fifo();
    fifo_en = 1; step(); chk("R4 fifo on idle", 8'hC1);
    rx_rdy = 1;  step(); chk("R4 fifo on rdy", 8'hC4);
    rx_rdy = 0; fifo_en = 0; step(); chk("R4 fifo off", 8'h01);
  endtask

  task automatic t_thr();
    pulse_tx(); chk("R5 thr latched", 8'h02);
    rx_rdy = 1; step(); do_read();
    rx_rdy = 0; step(); chk("R5 thr survives other read", 8'h02);
    do_read(); chk("R5 thr cleared by own read", 8'h01);
  endtask

  task automatic t_mask();
    src_en = 7'b1111110; line_err = 1; rx_rdy = 1; step();
    chk("R3 line masked", 8'h04);
    src_en = 7'b1111010; step();
    chk("R3 all masked", 8'h01);
    line_err = 0; rx_rdy = 0; src_en = 7'h7F; step();
  endtask

  task automatic t_xoff_flow();
    enh = 1; step();
    pulse_xoff(); chk("R6 xoff latched", 8'h10);
    pulse_rxc();  chk("R6 rx char keeps xoff", 8'h10);
    do_read();    chk("R6 xoff read clear", 8'h01);
    xoff = 1; flow = 1; step(); xoff = 0; flow = 0;
    chk("R2 xoff above flow", 8'h10);
    do_read(); chk("R8 flow after xoff read", 8'h20);
    do_read(); chk("R8 flow read clear", 8'h01);
  endtask

  task automatic t_spec();
    pulse_spec(); chk("R7 special latched", 8'h10);
    pulse_rxc();  chk("R7 special auto clear", 8'h01);
    pulse_spec(); do_read(); chk("R7 special read clear", 8'h01);
  endtask

  task automatic t_enh();
    enh = 0; step();
    pulse_xoff(); pulse_flow(); pulse_spec();
    chk("R9 pulses ignored", 8'h01);
    enh = 1; step();
    chk("R9 nothing held", 8'h01);
    pulse_flow(); chk("R9 flow with enh", 8'h20);
    enh = 0; #1; chk("R9 hidden when off", 8'h01);
    step(); enh = 1; step();
    chk("R9 flag discarded", 8'h01);
  endtask

  initial begin
    rst_n = 0; line_err = 0; rx_tmo = 0; rx_rdy = 0; tx_pls = 0; mdm = 0;
    xoff = 0; spec = 0; flow = 0; src_en = 7'h7F; enh = 0; fifo_en = 0;
    rd = 0; rxc = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();
    t_reset();
    t_levels();
    t_fifo();
    t_thr();
    t_mask();
    t_xoff_flow();
    t_spec();
    t_enh();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule